// File: doc/BRIEF.md
# Serial-Fed Paper Tape Reader

This block stands in for the paper tape reader of a small 18-bit computer. The tape itself lives on a host machine, which sends the tape frames as bytes over an asynchronous serial line (one start bit, eight data bits least significant first, one stop bit, line idle high). The processor starts a read with an I/O instruction pulse together with one of two read selects. The block then sends a one-byte request to the host on its own transmit line and decodes the bytes that come back.

In binary mode only bytes with their top bit set count as tape frames. The low six bits of three such bytes are packed into one 18-bit reader buffer, the first group landing in the most significant position. In alphanumeric mode a single byte fills the buffer. When the buffer is complete, a loaded flag rises. A third select, given with the instruction pulse, copies the buffer onto the 18-bit I/O bus and pulses a completion strobe. The processor acknowledges the transfer with a separate handshake input, which clears the loaded flag.

Top module: `tape_reader`

## Requirements
- R1: After reset `txd` is high, `done` and `rb_loaded` are low and `io_word` is zero.
- R2: Both serial directions use 8N1 framing: a low start bit, eight data bits sent least significant bit first, then a high stop bit, each bit lasting CLKS_PER_BIT clocks.
- R3: `iot_pulse` high with `sel_binary` for one clock starts a binary read and sends request byte 0x01 on `txd`; `iot_pulse` with `sel_alpha` starts an alphanumeric read and sends request byte 0x02.
- R4: During a binary read a received byte whose bit 7 is 0 is ignored: it adds no group to the buffer, does not advance the group count, and `rb_loaded` stays low.
- R5: During a binary read the low six bits of three bytes with bit 7 set are packed so that the first group lands in `io_word[17:12]`, the second in `io_word[11:6]` and the third in `io_word[5:0]`; `rb_loaded` rises after the third such byte and not before.
- R6: During an alphanumeric read the first received byte, whatever its bit 7, completes the read: the buffer becomes the byte in bits 7:0 with bits 17:8 cleared, and `rb_loaded` rises.
- R7: `iot_pulse` with `sel_rdbuf` copies the buffer onto `io_word` and drives `done` high for exactly one clock; `io_word` changes only together with `done`.
- R8: A high `io_loaded` clears `rb_loaded`.
- R9: A low pulse on `rxd` that is no longer low at the middle of the start bit is discarded and produces no byte.
- R10: A byte received while no read is in progress leaves the buffer and `rb_loaded` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_pulse | input | 1 | One-clock I/O instruction strobe |
| sel_alpha | input | 1 | Selects an alphanumeric read |
| sel_binary | input | 1 | Selects a binary read |
| sel_rdbuf | input | 1 | Selects copying the buffer to the I/O bus |
| io_loaded | input | 1 | Acknowledge from the processor, clears rb_loaded |
| rxd | input | 1 | Serial data from the host |
| txd | output | 1 | Serial request line to the host |
| io_word | output | 18 | I/O bus word, bit 17 most significant |
| done | output | 1 | One-clock completion strobe of a buffer read |
| rb_loaded | output | 1 | Reader buffer holds a complete word |

## Verification
The binary path is fed a mix of marked and unmarked bytes with distinct six-bit groups, so a byte taken in the wrong slot, an unmarked byte counted, or a reversed packing order each yields a different word. An all-ones group beside an all-zeros group exposes a short start-bit glitch wrongly taken as a byte. Alphanumeric reads use one byte with bit 7 clear and one with it set, separating correct zero-extension from any frame filtering leaking into that mode. A byte sent with no read active, followed by a buffer read, shows the buffer was left alone.

// File: rtl/tape_reader_pkg.sv
package tape_reader_pkg;
  localparam int WORD_W = 18;
  localparam int GRP_W  = 6;
  localparam int GRPS   = WORD_W / GRP_W;
  localparam logic [7:0] REQ_BINARY = 8'h01;
  localparam logic [7:0] REQ_ALPHA  = 8'h02;

  typedef enum logic [1:0] {RD_IDLE, RD_BINARY, RD_ALPHA} rd_mode_e;

  function automatic logic is_marked(input logic [7:0] b);
    return b[7];
  endfunction

  // Older groups move up; the newest group enters at the low end.
  function automatic logic [WORD_W-1:0] push_group(input logic [WORD_W-1:0] w,
                                                   input logic [7:0] b);
    return {w[WORD_W-GRP_W-1:0], b[GRP_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] alpha_word(input logic [7:0] b);
    return {{(WORD_W-8){1'b0}}, b};
  endfunction
endpackage

// File: rtl/tape_serial_rx.sv
module tape_serial_rx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [2:0]     bit_idx;
  logic [7:0]     shreg;
  logic           rx_q1, rx_q2;

  // Start bit gone high again by its centre: treated as noise.
  logic start_glitch;
  assign start_glitch = (state == RX_START) && (cnt == MID) && rx_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_q2 <= 1'b1;
      state <= RX_IDLE;
      cnt <= '0;
      bit_idx <= '0;
      shreg <= '0;
      byte_valid <= 1'b0;
      byte_data <= '0;
    end else begin
      rx_q1 <= rxd;
      rx_q2 <= rx_q1;
      byte_valid <= 1'b0;
      case (state)
        RX_IDLE: if (!rx_q2) begin
          state <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == MID) begin
          cnt <= '0;
          bit_idx <= '0;
          state <= rx_q2 ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (cnt == LAST) begin
          cnt <= '0;
          shreg <= {rx_q2, shreg[7:1]};
          if (bit_idx == 3'd7) state <= RX_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == LAST) begin
          state <= RX_IDLE;
          cnt <= '0;
          if (rx_q2) begin
            byte_valid <= 1'b1;
            byte_data <= shreg;
          end
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R9
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |=> (state == RX_IDLE) && !byte_valid);
endmodule

// File: rtl/tape_serial_tx.sv
module tape_serial_tx #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send,
  input  logic [7:0] data,
  output logic       txd
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [9:0]    frame;
  logic [3:0]    bits_left;
  logic [CW-1:0] cnt;
  logic          busy;

  assign txd = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1;
      bits_left <= '0;
      cnt <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (send) begin
        frame <= {1'b1, data, 1'b0};
        bits_left <= 4'd10;
        cnt <= '0;
        busy <= 1'b1;
      end
    end else if (cnt == LAST) begin
      cnt <= '0;
      frame <= {1'b1, frame[9:1]};
      bits_left <= bits_left - 1'b1;
      if (bits_left == 4'd1) busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tape_reader_ctrl.sv
module tape_reader_ctrl
  import tape_reader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_pulse,
  input  logic              sel_alpha,
  input  logic              sel_binary,
  input  logic              sel_rdbuf,
  input  logic              io_loaded,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_send,
  output logic [7:0]        tx_data,
  output logic [WORD_W-1:0] io_word,
  output logic              done,
  output logic              rb_loaded
);
  localparam int CNT_W = $clog2(GRPS);
  localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(GRPS - 1);

  rd_mode_e          mode;
  logic [CNT_W-1:0]  grp_cnt;
  logic [WORD_W-1:0] rbuf;

  logic start_bin, start_alpha, starting, rdbuf_cmd, rx_take;
  logic frame_take, frame_skip, word_done;

  assign start_bin   = iot_pulse && sel_binary;
  assign start_alpha = iot_pulse && sel_alpha && !sel_binary;
  assign starting    = start_bin || start_alpha;
  assign rdbuf_cmd   = iot_pulse && sel_rdbuf && !sel_binary && !sel_alpha;
  assign rx_take     = rx_valid && !starting;
  assign frame_take  = rx_take && (mode == RD_BINARY) && is_marked(rx_byte);
  assign frame_skip  = rx_take && (mode == RD_BINARY) && !is_marked(rx_byte);
  assign word_done   = (frame_take && grp_cnt == LAST_GRP) ||
                       (rx_take && mode == RD_ALPHA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= RD_IDLE;
      grp_cnt <= '0;
      rbuf <= '0;
      tx_send <= 1'b0;
      tx_data <= '0;
      io_word <= '0;
      done <= 1'b0;
      rb_loaded <= 1'b0;
    end else begin
      tx_send <= 1'b0;
      done <= 1'b0;
      if (start_bin) begin
        mode <= RD_BINARY;
        grp_cnt <= '0;
        tx_send <= 1'b1;
        tx_data <= REQ_BINARY;
      end else if (start_alpha) begin
        mode <= RD_ALPHA;
        grp_cnt <= '0;
        tx_send <= 1'b1;
        tx_data <= REQ_ALPHA;
      end else if (word_done) begin
        mode <= RD_IDLE;
        grp_cnt <= '0;
        rbuf <= (mode == RD_ALPHA) ? alpha_word(rx_byte) : push_group(rbuf, rx_byte);
      end else if (frame_take) begin
        rbuf <= push_group(rbuf, rx_byte);
        grp_cnt <= grp_cnt + 1'b1;
      end
      if (rdbuf_cmd) begin
        io_word <= rbuf;
        done <= 1'b1;
      end
      if (word_done) rb_loaded <= 1'b1;
      else if (io_loaded) rb_loaded <= 1'b0;
    end
  end

  // R4
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_skip |=> $stable(grp_cnt) && $stable(rbuf));
  // R5
  rb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rb_loaded);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rdbuf_cmd));
  // R7
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_word) |-> done);
  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && mode == RD_IDLE) |=> $stable(rbuf));
endmodule

// File: rtl/tape_reader.sv
module tape_reader
  import tape_reader_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_pulse,
  input  logic              sel_alpha,
  input  logic              sel_binary,
  input  logic              sel_rdbuf,
  input  logic              io_loaded,
  input  logic              rxd,
  output logic              txd,
  output logic [WORD_W-1:0] io_word,
  output logic              done,
  output logic              rb_loaded
);
  logic       rx_valid, tx_send;
  logic [7:0] rx_byte, tx_data;

  tape_serial_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .byte_valid(rx_valid), .byte_data(rx_byte));

  tape_serial_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .send(tx_send), .data(tx_data), .txd(txd));

  tape_reader_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .iot_pulse(iot_pulse),
    .sel_alpha(sel_alpha), .sel_binary(sel_binary), .sel_rdbuf(sel_rdbuf),
    .io_loaded(io_loaded), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_send(tx_send), .tx_data(tx_data), .io_word(io_word),
    .done(done), .rb_loaded(rb_loaded));
endmodule

// File: tb/test_tape_reader.sv
module test_tape_reader;
  localparam int CPB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iot_pulse = 1'b0, sel_alpha = 1'b0, sel_binary = 1'b0, sel_rdbuf = 1'b0;
  logic io_loaded = 1'b0;
  logic rxd = 1'b1;
  logic txd, done, rb_loaded;
  logic [17:0] io_word;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [17:0] word_q[$];
  logic [7:0]  req_q[$];

  always #5 clk = ~clk;

  tape_reader #(.CLKS_PER_BIT(CPB)) i_tape_reader (
    .clk(clk), .rst_n(rst_n), .iot_pulse(iot_pulse), .sel_alpha(sel_alpha),
    .sel_binary(sel_binary), .sel_rdbuf(sel_rdbuf), .io_loaded(io_loaded),
    .rxd(rxd), .txd(txd), .io_word(io_word), .done(done), .rb_loaded(rb_loaded));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Pack three six-bit groups, first one most significant (R5)
  function automatic logic [17:0] pack3(input logic [7:0] a, b, c);
    logic [17:0] w;
    w[17:12] = a[5:0];
    w[11:6]  = b[5:0];
    w[5:0]   = c[5:0];
    return w;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0; ticks(CPB);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; ticks(CPB);
    end
    rxd = 1'b1; ticks(CPB);
    ticks(4);
  endtask

  task automatic start_read(input bit binary);
    req_q.push_back(binary ? 8'h01 : 8'h02);
    iot_pulse = 1'b1; sel_binary = binary; sel_alpha = !binary;
    ticks(1);
    iot_pulse = 1'b0; sel_binary = 1'b0; sel_alpha = 1'b0;
    ticks(1);
  endtask

  task automatic read_buf(input logic [17:0] exp);
    word_q.push_back(exp);
    iot_pulse = 1'b1; sel_rdbuf = 1'b1;
    ticks(1);
    iot_pulse = 1'b0; sel_rdbuf = 1'b0;
    ticks(3);
  endtask

  task automatic ack();
    io_loaded = 1'b1; ticks(1); io_loaded = 1'b0; ticks(1);
    chk(rb_loaded == 1'b0, "R8 rb_loaded after io_loaded", 32'(rb_loaded), 0);
  endtask

  // Monitor: buffer words arriving on the I/O bus
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        chk(done == 1'b0, "R7 done one clock", 32'(done), 0);
      if (done) begin
        if (word_q.size() == 0) chk(1'b0, "R7 unexpected done", 32'(io_word), 0);
        else begin
          logic [17:0] e;
          e = word_q.pop_front();
          chk(io_word == e, "R5/R6 io_word", 32'(io_word), 32'(e));
        end
      end
      prev_done = done;
    end
  end

  // Monitor: request bytes on txd (R2, R3)
  initial begin
    logic [7:0] got;
    @(posedge rst_n);
    forever begin
      do @(negedge clk); while (txd !== 1'b0);
      ticks(CPB / 2);
      for (int i = 0; i < 8; i++) begin
        ticks(CPB);
        got[i] = txd;
      end
      ticks(CPB);
      chk(txd == 1'b1, "R2 tx stop bit", 32'(txd), 1);
      if (req_q.size() == 0) chk(1'b0, "R3 unexpected request", 32'(got), 0);
      else begin
        logic [7:0] e;
        e = req_q.pop_front();
        chk(got == e, "R3 request byte", 32'(got), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    wrap_up();
  end

  initial begin
    ticks(3);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", 32'(txd), 1);
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(rb_loaded == 1'b0, "R1 rb_loaded", 32'(rb_loaded), 0);
    chk(io_word == '0, "R1 io_word", 32'(io_word), 0);
    rst_n = 1'b1;
    ticks(2);

    // Binary read with an unmarked byte in between (R4, R5)
    start_read(1'b1);
    send_byte(8'h85);
    send_byte(8'h3F);
    chk(rb_loaded == 1'b0, "R4 unmarked not counted", 32'(rb_loaded), 0);
    send_byte(8'h8C);
    chk(rb_loaded == 1'b0, "R5 two groups only", 32'(rb_loaded), 0);
    send_byte(8'hB8);
    chk(rb_loaded == 1'b1, "R5 rb_loaded after third", 32'(rb_loaded), 1);
    read_buf(pack3(8'h85, 8'h8C, 8'hB8));
    ack();

    // Alphanumeric read, bit 7 clear (R6)
    start_read(1'b0);
    send_byte(8'h3F);
    chk(rb_loaded == 1'b1, "R6 alpha completes", 32'(rb_loaded), 1);
    read_buf(18'h0003F);
    ack();

    // Byte with no read in progress (R10)
    send_byte(8'h81);
    chk(rb_loaded == 1'b0, "R10 idle byte", 32'(rb_loaded), 0);
    read_buf(18'h0003F);

    // Start-bit glitch during a binary read (R9)
    start_read(1'b1);
    ticks(4);
    rxd = 1'b0; ticks(3); rxd = 1'b1; ticks(2 * CPB);
    send_byte(8'hBF);
    send_byte(8'h80);
    chk(rb_loaded == 1'b0, "R9 glitch not a group", 32'(rb_loaded), 0);
    send_byte(8'hAA);
    chk(rb_loaded == 1'b1, "R9 word complete", 32'(rb_loaded), 1);
    read_buf(pack3(8'hBF, 8'h80, 8'hAA));
    ack();

    // Alphanumeric read, bit 7 set (R6)
    start_read(1'b0);
    send_byte(8'hC5);
    read_buf(18'h000C5);
    ack();

    ticks(12 * CPB);
    chk(req_q.size() == 0, "R3 all requests seen", 32'(req_q.size()), 0);
    chk(word_q.size() == 0, "R7 all words seen", 32'(word_q.size()), 0);
    wrap_up();
  end
endmodule